// File: doc/BRIEF.md
# Bus Master Write Command Selector

This block sits inside a bus-master DMA engine that moves received data into host memory. Every time the engine has buffered data to write and no burst is running, it picks the command for the next burst. The choice is Memory Write and Invalidate (code 1111) when the burst can be guaranteed to fill whole cache lines, and plain Memory Write (code 0111) otherwise. It announces each new burst with a one-cycle strobe.

While a burst runs, the bus interface reports each completed DWord data phase and presents the address of the phase in flight and the byte count still buffered. On the last DWord of every cache line the selector decides whether the burst may run on or must end at that boundary. An invalidate burst ends there once less than a full line would remain after the current phase. A plain write burst ends there only when the terminate-on-line setting is on; with the setting off, it runs through boundaries until the data runs out. After any burst ends, the next command is chosen again from the conditions present at that time.

The cache line size is given in DWords. Only the low address bits that cover one maximum-size line are taken in, because line position is the only thing the block needs from the address.

Top module: `wr_cmd_sel`

## Requirements
- R1: While reset is held and after it is released, cmd is 0111, start is 0 and term is 0 until a burst is launched.
- R2: When req is high in an idle cycle and all of these hold: inv_en=1, cls_dw is a power of two from 8 to 16, address bits [1:0] are zero with the DWord index modulo cls_dw equal to zero, and avail_bytes >= 4*cls_dw, then start is 1 and cmd is 1111 in the cycle after that edge.
- R3: When req is high in an idle cycle with avail_bytes nonzero and any condition of R2 is false (invalidate disabled, size 0 or unsupported such as 12, address off a line boundary, or less than one line buffered), start is 1 and cmd is 0111 in the next cycle.
- R4: In an invalidate burst, term is 1 during a phase whose DWord index modulo cls_dw equals cls_dw-1 exactly when avail_bytes - 4 < 4*cls_dw, and term is 0 on every phase that is not the last DWord of a line.
- R5: In an invalidate burst, when at least one full line remains after the last DWord of a line, term stays 0 and the burst carries on with cmd 1111.
- R6: In a plain write burst with term_on_line=1, term is 1 during the last DWord of each cache line.
- R7: In a plain write burst with term_on_line=0, term stays 0 at every line boundary and the burst runs until the buffered data is used up.
- R8: A burst ends at the edge where xfer=1 and either term=1 or avail_bytes <= 4. The next burst's command is chosen afresh from the R2 conditions, and cmd does not change inside a burst.
- R9: start is high for exactly one cycle per burst. A req during a running burst, or a req while avail_bytes is 0, produces no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| cls_dw | input | 8 | Cache line size in DWords |
| inv_en | input | 1 | Invalidate-command enable from the command register |
| term_on_line | input | 1 | End plain write bursts on each cache-line boundary |
| addr_lo | input | 10 | Low byte-address bits of the data phase in flight |
| avail_bytes | input | 12 | Bytes buffered and not yet transferred, including the phase in flight |
| req | input | 1 | Engine has data to write and wants a burst |
| xfer | input | 1 | Current data phase completes at this edge |
| cmd | output | 4 | Bus command code: 0111 plain write, 1111 write and invalidate |
| start | output | 1 | One-cycle strobe in the first cycle of a burst |
| term | output | 1 | Request to end the burst after the current data phase |

## Verification
The command and the start strobe come from registers, so they are due one clock after the edge that samples req in an idle cycle. The bench drives inputs on the falling edge and reads these outputs on the next falling edge. The terminate request is combinational on the current phase's address, buffer count and burst state, so the bench reads it shortly after setting each phase's inputs, in the same cycle. The end of a burst shows one edge later, as an idle cycle with no strobe.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MW   = 2'd1,
    ST_MWI  = 2'd2
  } wcs_state_e;

  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MWI = 4'b1111;
endpackage

// File: rtl/wcs_line_geom.sv
module wcs_line_geom #(
  parameter int CLS_W      = 8,
  parameter int AVAIL_W    = 12,
  parameter int MIN_CLS_DW = 8,
  parameter int MAX_CLS_DW = 16
) (
  input  logic [CLS_W-1:0]   cls_dw,
  input  logic [CLS_W+1:0]   addr_lo,
  output logic               cls_ok,
  output logic               aligned,
  output logic               at_last,
  output logic [AVAIL_W-1:0] line_bytes
);
  localparam int PAD_W = AVAIL_W - CLS_W - 2;

  logic [CLS_W-1:0] mask;
  logic [CLS_W-1:0] offset;

  always_comb begin
    mask       = cls_dw - 1'b1;
    offset     = addr_lo[CLS_W+1:2] & mask;
    cls_ok     = (cls_dw != '0) && ((cls_dw & mask) == '0) &&
                 (cls_dw >= CLS_W'(MIN_CLS_DW)) && (cls_dw <= CLS_W'(MAX_CLS_DW));
    aligned    = (addr_lo[1:0] == 2'b00) && (offset == '0);
    at_last    = (offset == mask);
    line_bytes = {{PAD_W{1'b0}}, cls_dw, 2'b00};
  end
endmodule

// File: rtl/wcs_policy.sv
module wcs_policy #(
  parameter int AVAIL_W = 12
) (
  input  logic               inv_en,
  input  logic               term_on_line,
  input  logic               cls_ok,
  input  logic               aligned,
  input  logic               at_last,
  input  logic [AVAIL_W-1:0] line_bytes,
  input  logic [AVAIL_W-1:0] avail_bytes,
  input  logic               in_mw,
  input  logic               in_mwi,
  output logic               mwi_start_ok,
  output logic               term
);
  logic [AVAIL_W:0] hold_need;
  logic             mwi_hold_ok;

  always_comb begin
    hold_need    = {1'b0, line_bytes} + (AVAIL_W+1)'(4);
    mwi_start_ok = inv_en && cls_ok && aligned && (avail_bytes >= line_bytes);
    mwi_hold_ok  = inv_en && cls_ok && ({1'b0, avail_bytes} >= hold_need);
    term         = at_last && ((in_mwi && !mwi_hold_ok) || (in_mw && term_on_line));
  end
endmodule

// File: rtl/wr_cmd_sel.sv
module wr_cmd_sel
  import wcs_pkg::*;
#(
  parameter int CLS_W      = 8,
  parameter int AVAIL_W    = 12,
  parameter int MIN_CLS_DW = 8,
  parameter int MAX_CLS_DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CLS_W-1:0]   cls_dw,
  input  logic               inv_en,
  input  logic               term_on_line,
  input  logic [CLS_W+1:0]   addr_lo,
  input  logic [AVAIL_W-1:0] avail_bytes,
  input  logic               req,
  input  logic               xfer,
  output logic [3:0]         cmd,
  output logic               start,
  output logic               term
);
  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  wcs_state_e         state_q, state_d;
  logic               start_q, start_d;
  logic [3:0]         cmd_q, cmd_d;
  logic               cmd_en;
  logic               cls_ok, aligned, at_last;
  logic [AVAIL_W-1:0] line_bytes;
  logic               mwi_start_ok;
  logic               last_data;
  logic               burst_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  wcs_line_geom #(
    .CLS_W(CLS_W), .AVAIL_W(AVAIL_W),
    .MIN_CLS_DW(MIN_CLS_DW), .MAX_CLS_DW(MAX_CLS_DW)
  ) u_geom (
    .cls_dw(cls_dw), .addr_lo(addr_lo), .cls_ok(cls_ok),
    .aligned(aligned), .at_last(at_last), .line_bytes(line_bytes)
  );

  wcs_policy #(.AVAIL_W(AVAIL_W)) u_policy (
    .inv_en(inv_en), .term_on_line(term_on_line), .cls_ok(cls_ok),
    .aligned(aligned), .at_last(at_last), .line_bytes(line_bytes),
    .avail_bytes(avail_bytes), .in_mw(state_q == ST_MW),
    .in_mwi(state_q == ST_MWI), .mwi_start_ok(mwi_start_ok), .term(term)
  );

  always_comb begin
    last_data = (avail_bytes <= AVAIL_W'(4));
    burst_end = xfer && (term || last_data);
    state_d   = state_q;
    start_d   = 1'b0;
    cmd_d     = cmd_q;
    cmd_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req && (avail_bytes != '0)) begin
          start_d = 1'b1;
          cmd_en  = 1'b1;
          if (mwi_start_ok) begin
            state_d = ST_MWI;
            cmd_d   = CMD_MWI;
          end else begin
            state_d = ST_MW;
            cmd_d   = CMD_MW;
          end
        end
      end
      ST_MW, ST_MWI: begin
        if (burst_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      cmd_q   <= CMD_MW;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  assign cmd   = cmd_q;
  assign start = start_q;

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    start_q |=> !start_q);

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_IDLE && !start_q) |-> $stable(cmd_q));

  assert_mwi_launch_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start_q && cmd_q == CMD_MWI) |-> ($past(inv_en) && $past(aligned) && $past(cls_ok)));

  assert_mw_runs_through_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_MW && !term_on_line) |-> !term);

  assert_term_at_line_end_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    term |-> at_last);

  assert_idle_no_term_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_IDLE) |-> !term);
endmodule

// File: tb/wr_cmd_sel_test.sv
`timescale 1ns/100ps
module wr_cmd_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cls_dw;
  logic        inv_en, term_on_line, req, xfer;
  logic [9:0]  addr_lo;
  logic [11:0] avail_bytes;
  logic [3:0]  cmd;
  logic        start, term;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  wr_cmd_sel uut (
    .clk(clk), .rst_n(rst_n), .cls_dw(cls_dw), .inv_en(inv_en),
    .term_on_line(term_on_line), .addr_lo(addr_lo), .avail_bytes(avail_bytes),
    .req(req), .xfer(xfer), .cmd(cmd), .start(start), .term(term)
  );

  // row: addr[15:0] avail[11:0] cls[7:0] inv tol exp_mwi len[7:0] exp_term
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0100, 12'd64,  8'd8,  1'b1, 1'b0, 1'b1, 8'd16, 1'b1},
    {16'h0100, 12'd48,  8'd8,  1'b1, 1'b0, 1'b1, 8'd8,  1'b1},
    {16'h0100, 12'd48,  8'd8,  1'b0, 1'b0, 1'b0, 8'd12, 1'b0},
    {16'h0100, 12'd48,  8'd8,  1'b0, 1'b1, 1'b0, 8'd8,  1'b1},
    {16'h0120, 12'd64,  8'd8,  1'b0, 1'b0, 1'b0, 8'd16, 1'b0},
    {16'h0108, 12'd64,  8'd8,  1'b1, 1'b1, 1'b0, 8'd6,  1'b1},
    {16'h0100, 12'd32,  8'd12, 1'b1, 1'b0, 1'b0, 8'd8,  1'b0},
    {16'h0100, 12'd32,  8'd0,  1'b1, 1'b0, 1'b0, 8'd8,  1'b0},
    {16'h0100, 12'd28,  8'd8,  1'b1, 1'b1, 1'b0, 8'd7,  1'b0},
    {16'h0200, 12'd96,  8'd16, 1'b1, 1'b0, 1'b1, 8'd16, 1'b1},
    {16'h0200, 12'd128, 8'd16, 1'b1, 1'b0, 1'b1, 8'd32, 1'b1},
    {16'h0100, 12'd48,  8'd8,  1'b1, 1'b1, 1'b1, 8'd8,  1'b1},
    {16'h0120, 12'd16,  8'd8,  1'b1, 1'b0, 1'b0, 8'd4,  1'b0},
    {16'h0100, 12'd32,  8'd8,  1'b1, 1'b1, 1'b1, 8'd8,  1'b1}
  };

  task automatic show_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      show_summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // launch one burst and run it to its end, checking strobe, command and term
  task automatic run_burst(input logic [47:0] v, input int row);
    logic [15:0] a0;
    logic [11:0] av0;
    int          len;
    logic        exp_mwi, exp_term;
    a0 = v[47:32]; av0 = v[31:20]; exp_mwi = v[9]; len = int'(v[8:1]); exp_term = v[0];
    @(negedge clk);
    cls_dw = v[19:12]; inv_en = v[11]; term_on_line = v[10];
    addr_lo = a0[9:0]; avail_bytes = av0; req = 1'b1; xfer = 1'b0;
    @(negedge clk);
    // R2 / R3: strobe and command one edge after the idle request
    check($sformatf("R2_R3 row%0d start", row), 32'(start), 32'd1);
    check($sformatf("R2_R3 row%0d cmd", row), 32'(cmd), exp_mwi ? 32'hF : 32'h7);
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      addr_lo = a0[9:0] + 10'(4*i);
      avail_bytes = av0 - 12'(4*i);
      xfer = 1'b1;
      req = (i < len - 1);
      #1;
      if (i > 0) check($sformatf("R9 row%0d phase%0d start", row, i), 32'(start), 32'd0);
      // R4 R5 R6 R7: term only on the final phase, and only when expected
      check($sformatf("R4_R5_R6_R7 row%0d phase%0d term", row, i), 32'(term),
            (i == len - 1) ? 32'(exp_term) : 32'd0);
      check($sformatf("R8 row%0d phase%0d cmd", row, i), 32'(cmd), exp_mwi ? 32'hF : 32'h7);
    end
    @(negedge clk);
    xfer = 1'b0; req = 1'b0;
    #1;
    // R8: burst over, idle with no strobe and no term
    check($sformatf("R8 row%0d end start", row), 32'(start), 32'd0);
    check($sformatf("R8 row%0d end term", row), 32'(term), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cls_dw = 8'd8; inv_en = 1'b0; term_on_line = 1'b0;
    addr_lo = '0; avail_bytes = '0; req = 1'b0; xfer = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset cmd", 32'(cmd), 32'h7);
    check("R1 in reset start", 32'(start), 32'd0);
    check("R1 in reset term", 32'(term), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release cmd", 32'(cmd), 32'h7);
    check("R1 after release start", 32'(start), 32'd0);

    for (int r = 0; r < NV; r++) run_burst(VEC[r], r);

    // R9: request with empty buffer gives no burst
    @(negedge clk);
    inv_en = 1'b1; addr_lo = 10'h100; avail_bytes = 12'd0; req = 1'b1;
    @(negedge clk);
    check("R9 empty buffer start", 32'(start), 32'd0);
    @(negedge clk);
    check("R9 empty buffer start again", 32'(start), 32'd0);
    check("R9 empty buffer cmd", 32'(cmd), 32'hF);
    req = 1'b0;

    // terminate bit toggles between bursts: set, then clear on the same data
    run_burst({16'h0100, 12'd48, 8'd8, 1'b0, 1'b1, 1'b0, 8'd8, 1'b1}, 100);
    run_burst({16'h0120, 12'd48, 8'd8, 1'b0, 1'b0, 1'b0, 8'd12, 1'b0}, 101);

    // R1: reset in the middle of an invalidate burst
    @(negedge clk);
    cls_dw = 8'd8; inv_en = 1'b1; term_on_line = 1'b0;
    addr_lo = 10'h100; avail_bytes = 12'd64; req = 1'b1;
    @(negedge clk);
    check("R2 pre-reset cmd", 32'(cmd), 32'hF);
    addr_lo = 10'h11C; avail_bytes = 12'd4; req = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 mid-burst reset cmd", 32'(cmd), 32'h7);
    check("R1 mid-burst reset term", 32'(term), 32'd0);
    check("R1 mid-burst reset start", 32'(start), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    show_summary();
    $finish;
  end
endmodule